// File: doc/BRIEF.md
# IDE Channel Address Decoder

This block holds the configuration byte registers of a two-channel IDE controller function and turns them into the I/O addresses that the rest of the chip decodes. A host writes and reads single bytes through an 8-bit offset port. From the stored bytes the block derives four values for each channel: the command block base, the control port, a decode enable, and the bus-master register block base.

Each channel has its own mode bit in the programming-interface byte. When the bit is clear, the channel uses the fixed compatibility ports. When the bit is set, the channel takes its ports from its pair of base address registers. A channel only decodes when the I/O space bit of the command register is set and the channel's own bit in the channel-enable byte is also set. Stored bytes pass through fixed write masks. Status bits are cleared by writing ones to them. The identification bytes cannot be written.

Top module: `ide_chan_decode`

## Requirements
- R1: After reset, offset 0x04 reads 0x80, 0x07 reads 0x02, 0x09 reads 0x85 and 0x40 reads 0x08. The base registers read 0x01F1 (0x10/0x11), 0x03F5 (0x14/0x15), 0x0171 (0x18/0x19) and 0x0375 (0x1C/0x1D). The bus-master base bytes 0x20/0x21 read 0xCC01.
- R2: A write to 0x09 stores (data & 0x05) | 0x8A. Bit 0 selects native mode for the primary channel and bit 2 selects it for the secondary channel.
- R3: A channel whose mode bit is 0 reports fixed ports. These are command 0x01F0 and control 0x03F6 for the primary channel, and 0x0170 and 0x0376 for the secondary channel.
- R4: A write to a command BAR low byte (0x10 primary, 0x18 secondary) stores (data & 0xF8) | 0x01. High bytes at 0x11/0x19 store the data unchanged. A native channel's command base is {high, low & 0xF8}.
- R5: A write to a control BAR low byte (0x14 primary, 0x1C secondary) stores (data & 0xFC) | 0x01. High bytes at 0x15/0x1D store the data unchanged. A native channel's control port is {high, low & 0xFC} + 2.
- R6: A write to 0x04 stores data & 0x85. Bit 0 is the I/O space enable.
- R7: pri_en is 0x04 bit 0 AND 0x40 bit 1. sec_en is 0x04 bit 0 AND 0x40 bit 0. Byte 0x40 stores data unchanged.
- R8: A write to 0x20 stores (data & 0xF0) | 0x01, and 0x21 stores data unchanged. bm0_base is {0x21, 0x20 & 0xF0} and bm1_base is bm0_base + 8.
- R9: A write to 0x07 clears each stored bit that is 1 in (data & 0xF1). Other bits keep their value.
- R10: Offsets 0x00..0x03 read the vendor and device identifiers, low byte first, and 0x08 reads the revision. Writes to them are discarded. Every other offset not listed here reads 0x00, except 0x06 (0x80) and 0x0A/0x0B (0x01).
- R11: Reads are combinational from the current offset. A write changes the stored byte and every derived output at the clock edge that samples it, and not before. Without a write, the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr |
| pri_cmd_base | output | 16 | Primary command block base |
| pri_ctl_port | output | 16 | Primary control port |
| sec_cmd_base | output | 16 | Secondary command block base |
| sec_ctl_port | output | 16 | Secondary control port |
| pri_en | output | 1 | Primary channel decode enable |
| sec_en | output | 1 | Secondary channel decode enable |
| bm0_base | output | 16 | Bus-master block base, channel 0 |
| bm1_base | output | 16 | Bus-master block base, channel 1 |

## Verification
Read data is due in the same cycle as the offset it answers. The bench applies an offset at the falling edge and samples one nanosecond later. A write is driven at a falling edge and takes effect at the next rising edge. The bench checks, just before that edge, that nothing has moved yet, and checks the new stored byte and all derived ports at the following falling edge. The bench's expected byte image is updated only at that point, so every comparison stays exactly one edge behind the write.

// File: rtl/ide_chan_decode.sv
module ide_chan_decode #(
  parameter logic [15:0] VENDOR_ID = 16'h1D0A,
  parameter logic [15:0] DEVICE_ID = 16'h0C51,
  parameter logic [7:0]  REVISION  = 8'h06,
  parameter logic [15:0] PRI_CMD_FIXED = 16'h01F0,
  parameter logic [15:0] PRI_CTL_FIXED = 16'h03F6,
  parameter logic [15:0] SEC_CMD_FIXED = 16'h0170,
  parameter logic [15:0] SEC_CTL_FIXED = 16'h0376
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  output logic [15:0] pri_cmd_base,
  output logic [15:0] pri_ctl_port,
  output logic [15:0] sec_cmd_base,
  output logic [15:0] sec_ctl_port,
  output logic        pri_en,
  output logic        sec_en,
  output logic [15:0] bm0_base,
  output logic [15:0] bm1_base
);

  logic [7:0] cmd_q, sts_q, pif_q, chen_q;
  logic [7:0] pcmd_lo, pcmd_hi, pctl_lo, pctl_hi;
  logic [7:0] scmd_lo, scmd_hi, sctl_lo, sctl_hi;
  logic [7:0] bm_lo, bm_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= 8'h80;
      sts_q   <= 8'h02;
      pif_q   <= 8'h85;
      chen_q  <= 8'h08;
      pcmd_lo <= 8'hF1; pcmd_hi <= 8'h01;
      pctl_lo <= 8'hF5; pctl_hi <= 8'h03;
      scmd_lo <= 8'h71; scmd_hi <= 8'h01;
      sctl_lo <= 8'h75; sctl_hi <= 8'h03;
      bm_lo   <= 8'h01; bm_hi   <= 8'hCC;
    end else if (cfg_we) begin
      case (cfg_addr)
        8'h04: cmd_q   <= cfg_wdata & 8'h85;
        8'h07: sts_q   <= sts_q & ~(cfg_wdata & 8'hF1);
        8'h09: pif_q   <= (cfg_wdata & 8'h05) | 8'h8A;
        8'h10: pcmd_lo <= {cfg_wdata[7:3], 3'b001};
        8'h11: pcmd_hi <= cfg_wdata;
        8'h14: pctl_lo <= {cfg_wdata[7:2], 2'b01};
        8'h15: pctl_hi <= cfg_wdata;
        8'h18: scmd_lo <= {cfg_wdata[7:3], 3'b001};
        8'h19: scmd_hi <= cfg_wdata;
        8'h1C: sctl_lo <= {cfg_wdata[7:2], 2'b01};
        8'h1D: sctl_hi <= cfg_wdata;
        8'h20: bm_lo   <= {cfg_wdata[7:4], 4'b0001};
        8'h21: bm_hi   <= cfg_wdata;
        8'h40: chen_q  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      8'h00: cfg_rdata = VENDOR_ID[7:0];
      8'h01: cfg_rdata = VENDOR_ID[15:8];
      8'h02: cfg_rdata = DEVICE_ID[7:0];
      8'h03: cfg_rdata = DEVICE_ID[15:8];
      8'h04: cfg_rdata = cmd_q;
      8'h06: cfg_rdata = 8'h80;
      8'h07: cfg_rdata = sts_q;
      8'h08: cfg_rdata = REVISION;
      8'h09: cfg_rdata = pif_q;
      8'h0A: cfg_rdata = 8'h01;
      8'h0B: cfg_rdata = 8'h01;
      8'h10: cfg_rdata = pcmd_lo;
      8'h11: cfg_rdata = pcmd_hi;
      8'h14: cfg_rdata = pctl_lo;
      8'h15: cfg_rdata = pctl_hi;
      8'h18: cfg_rdata = scmd_lo;
      8'h19: cfg_rdata = scmd_hi;
      8'h1C: cfg_rdata = sctl_lo;
      8'h1D: cfg_rdata = sctl_hi;
      8'h20: cfg_rdata = bm_lo;
      8'h21: cfg_rdata = bm_hi;
      8'h40: cfg_rdata = chen_q;
      default: cfg_rdata = 8'h00;
    endcase
  end

  assign pri_cmd_base = pif_q[0] ? {pcmd_hi, pcmd_lo[7:3], 3'b000} : PRI_CMD_FIXED;
  assign pri_ctl_port = pif_q[0] ? {pctl_hi, pctl_lo[7:2], 2'b00} + 16'd2 : PRI_CTL_FIXED;
  assign sec_cmd_base = pif_q[2] ? {scmd_hi, scmd_lo[7:3], 3'b000} : SEC_CMD_FIXED;
  assign sec_ctl_port = pif_q[2] ? {sctl_hi, sctl_lo[7:2], 2'b00} + 16'd2 : SEC_CTL_FIXED;

  assign pri_en = cmd_q[0] & chen_q[1];
  assign sec_en = cmd_q[0] & chen_q[0];

  assign bm0_base = {bm_hi, bm_lo[7:4], 4'h0};
  assign bm1_base = bm0_base + 16'd8;

endmodule

// File: rtl/ide_chan_decode_chk.sv
module ide_chan_decode_chk #(
  parameter logic [15:0] VENDOR_ID = 16'h1D0A
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [7:0]  cfg_addr,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic [15:0] pri_cmd_base,
  input logic [15:0] pri_ctl_port,
  input logic [15:0] sec_cmd_base,
  input logic [15:0] sec_ctl_port,
  input logic        pri_en,
  input logic        sec_en,
  input logic [15:0] bm0_base,
  input logic [15:0] bm1_base
);

  assert_legacy_pri_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 8'h09 && !cfg_wdata[0]) |=>
      (pri_cmd_base == 16'h01F0 && pri_ctl_port == 16'h03F6));

  assert_legacy_sec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 8'h09 && !cfg_wdata[2]) |=>
      (sec_cmd_base == 16'h0170 && sec_ctl_port == 16'h0376));

  assert_io_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 8'h04 && !cfg_wdata[0]) |=> (!pri_en && !sec_en));

  assert_bm_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 8'h21) |=> (bm0_base[15:8] == $past(cfg_wdata)));

  assert_vendor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 8'h00) |-> (cfg_rdata == VENDOR_ID[7:0]));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(pri_cmd_base) && $stable(pri_ctl_port) && $stable(sec_cmd_base) &&
                 $stable(sec_ctl_port) && $stable(pri_en) && $stable(sec_en) && $stable(bm0_base)));

endmodule

bind ide_chan_decode ide_chan_decode_chk #(.VENDOR_ID(VENDOR_ID)) i_chk (.*);

// File: tb/test_ide_chan_decode.sv
module test_ide_chan_decode;
  localparam logic [15:0] VID = 16'h1D0A;
  localparam logic [15:0] DID = 16'h0C51;
  localparam logic [7:0]  REV = 8'h06;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h00, cfg_wdata = 8'h00, cfg_rdata;
  logic [15:0] pri_cmd_base, pri_ctl_port, sec_cmd_base, sec_ctl_port, bm0_base, bm1_base;
  logic pri_en, sec_en;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m [256];

  always #10 clk = ~clk;

  ide_chan_decode i_ide_chan_decode (.*);

  initial begin
    #(20 * 20000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired: got running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [7:0] wr_model(logic [7:0] a, logic [7:0] old, logic [7:0] v);
    case (a)
      8'h04: return v & 8'h85;
      8'h07: return old & ~(v & 8'hF1);
      8'h09: return (v & 8'h05) | 8'h8A;
      8'h10, 8'h18: return (v & 8'hF8) | 8'h01;
      8'h14, 8'h1C: return (v & 8'hFC) | 8'h01;
      8'h20: return (v & 8'hF0) | 8'h01;
      8'h11, 8'h15, 8'h19, 8'h1D, 8'h21, 8'h40: return v;
      default: return old;
    endcase
  endfunction

  function automatic logic [15:0] e_pcmd();
    return m[8'h09][0] ? {m[8'h11], m[8'h10] & 8'hF8} : 16'h01F0;
  endfunction
  function automatic logic [15:0] e_pctl();
    return m[8'h09][0] ? {m[8'h15], m[8'h14] & 8'hFC} + 16'd2 : 16'h03F6;
  endfunction
  function automatic logic [15:0] e_scmd();
    return m[8'h09][2] ? {m[8'h19], m[8'h18] & 8'hF8} : 16'h0170;
  endfunction
  function automatic logic [15:0] e_sctl();
    return m[8'h09][2] ? {m[8'h1D], m[8'h1C] & 8'hFC} + 16'd2 : 16'h0376;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, string tag);
    cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, m[a]);
  endtask

  task automatic chk_outs(string tag);
    chk({tag, " pri cmd R4 R3"}, pri_cmd_base, e_pcmd());
    chk({tag, " pri ctl R5 R3"}, pri_ctl_port, e_pctl());
    chk({tag, " sec cmd R4 R3"}, sec_cmd_base, e_scmd());
    chk({tag, " sec ctl R5 R3"}, sec_ctl_port, e_sctl());
    chk({tag, " pri en R7"}, pri_en, m[8'h04][0] & m[8'h40][1]);
    chk({tag, " sec en R7"}, sec_en, m[8'h04][0] & m[8'h40][0]);
    chk({tag, " bm0 R8"}, bm0_base, {m[8'h21], m[8'h20] & 8'hF0});
    chk({tag, " bm1 R8"}, bm1_base, {m[8'h21], m[8'h20] & 8'hF0} + 16'd8);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] v, string tag);
    logic [15:0] pre;
    @(negedge clk);
    pre = pri_cmd_base;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    #1;
    chk({tag, " no early change R11"}, pri_cmd_base, pre);
    @(negedge clk);
    cfg_we = 1'b0;
    m[a] = wr_model(a, m[a], v);
    rd(a, tag);
    chk_outs(tag);
  endtask

  initial begin
    logic [7:0] pick [16] = '{8'h00, 8'h03, 8'h04, 8'h07, 8'h08, 8'h09, 8'h10, 8'h11,
                              8'h14, 8'h15, 8'h18, 8'h1C, 8'h20, 8'h21, 8'h40, 8'h1D};
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    m[8'h00] = VID[7:0]; m[8'h01] = VID[15:8]; m[8'h02] = DID[7:0]; m[8'h03] = DID[15:8];
    m[8'h08] = REV; m[8'h06] = 8'h80; m[8'h0A] = 8'h01; m[8'h0B] = 8'h01;
    m[8'h04] = 8'h80; m[8'h07] = 8'h02; m[8'h09] = 8'h85; m[8'h40] = 8'h08;
    m[8'h10] = 8'hF1; m[8'h11] = 8'h01; m[8'h14] = 8'hF5; m[8'h15] = 8'h03;
    m[8'h18] = 8'h71; m[8'h19] = 8'h01; m[8'h1C] = 8'h75; m[8'h1D] = 8'h03;
    m[8'h20] = 8'h01; m[8'h21] = 8'hCC;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (pick[k]) rd(pick[k], "reset readback R1 R10");
    chk_outs("reset R1");
    chk("reset pri cmd R1", pri_cmd_base, 16'h01F0);
    chk("reset bm0 R1", bm0_base, 16'hCC00);

    wr(8'h09, 8'h00, "legacy both R2 R3");
    chk("legacy pri cmd R3", pri_cmd_base, 16'h01F0);
    chk("legacy sec ctl R3", sec_ctl_port, 16'h0376);
    wr(8'h09, 8'hFF, "native both R2");
    chk("pif mask R2", cfg_rdata, 8'h8F);
    wr(8'h10, 8'hFF, "bar low mask R4");
    wr(8'h14, 8'hFF, "ctl low mask R5");
    wr(8'h04, 8'hFF, "cmd mask R6");
    wr(8'h40, 8'h02, "pri only R7");
    chk("pri only en R7", {pri_en, sec_en}, 2'b10);
    wr(8'h40, 8'h01, "sec only R7");
    wr(8'h04, 8'h00, "io off R7");
    wr(8'h20, 8'hFF, "bm low mask R8");
    wr(8'h07, 8'hFF, "status w1c R9");
    chk("status bit1 kept R9", cfg_rdata, 8'h02);
    wr(8'h00, 8'h55, "id write discarded R10");
    wr(8'h08, 8'hAA, "rev write discarded R10");
    wr(8'h33, 8'h77, "unmapped R10");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, v;
      a = ($urandom % 8 == 0) ? 8'($urandom) : pick[$urandom % 16];
      v = 8'($urandom);
      wr(a, v, "random R2 R4 R5 R6 R7 R8 R9 R10 R11");
    end

    @(negedge clk);
    @(negedge clk);
    chk_outs("idle hold R11");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule